// File: doc/BRIEF.md
# Software-Loaded Variable-Page Translation Buffer

This block is a fully associative address translation buffer that software fills one entry at a time through a small register write port. Software first stages the virtual page number (with its valid flag and address-space tag), then the page attributes (page size and protection group). Finally it writes the physical page number. Only that last write commits a complete entry, into the slot named by a replacement index held in the control register. After each commit the index advances by itself.

A lookup port takes a 32-bit virtual address and, one clock later, returns a hit flag, the translated physical address, a cache-inhibit attribute, a 2-bit access-permission mode and the page protection bits. Five page sizes (1 KB, 4 KB, 16 KB, 512 KB, 8 MB) live side by side in the same array. A global invalidate clears the buffer. A reserve bit shields the top four slots from that invalidate. When translation is switched off, the block passes addresses through unchanged and supplies a default cache-inhibit attribute.

Top module: `sw_tlb`

## Requirements
- R1: The buffer holds 32 entries and any valid entry, whatever its slot, can match any virtual address.
- R2: Page size code in attribute-register bits [2:0]: 0 = 1 KB, 1 = 4 KB, 2 = 16 KB, 3 = 512 KB, 4 = 8 MB, 5 to 7 = 1 KB. A hit compares virtual bits [31:k] with the stored page number and returns physical bits [31:k] from the stored physical page with virtual bits [k-1:0] passed through, where k is 10, 12, 14, 19 or 23.
- R3: Register selects are 0 control, 1 virtual page, 2 attributes, 3 physical page, 4 address-space ID, 5 access groups. Writes to selects 1 and 2 only stage data, and the array changes only on a select-3 write.
- R4: The control register field [12:8] sets the slot that the next commit overwrites.
- R5: After every commit the index advances by one and wraps from 31 to 0. When the reserve bit is 1, an index of 27 advances to 0.
- R6: A one-cycle pulse on `invAll` with the reserve bit (control bit 27) at 0 makes every entry invalid.
- R7: With the reserve bit at 1, `invAll` leaves slots 28 to 31 intact and invalidates the rest.
- R8: With `xlateEn` low, the result is hit = 1, physical address = virtual address, cache-inhibit = control bit 29, access mode = 01, protection = 00.
- R9: An entry matches only if its address-space tag (virtual-page register bits [3:0]) equals the current ID register (bits [3:0], reset value 0).
- R10: On a hit, the access mode is the 2-bit field [2g+1:2g] of the access-group register, where g is the entry's group (attribute bits [7:4]), read at lookup time. The cache-inhibit output is physical-page bit 1 and the protection output is physical-page bits [5:4]. The entry's valid flag is virtual-page bit 9.
- R11: When several entries match, the lowest-numbered slot supplies the result.
- R12: A miss with translation on gives hit = 0 and all other result fields 0. After reset, every entry is invalid.
- R13: A lookup result appears on the outputs at the first rising clock edge after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgSel | input | 3 | Register select |
| cfgWrData | input | 32 | Register write data |
| invAll | input | 1 | Global invalidate pulse |
| xlateEn | input | 1 | Translation enable |
| lkVa | input | 32 | Lookup virtual address |
| lkHit | output | 1 | Lookup hit |
| lkPa | output | 32 | Translated physical address |
| lkCi | output | 1 | Cache-inhibit attribute |
| lkAp | output | 2 | Access-permission mode |
| lkPp | output | 2 | Page protection bits |

## Verification
A register write or an invalidate pulse takes effect at the rising edge where it is sampled. A lookup launched in the following cycle already sees the new array contents. A lookup result is registered once, so it is due at the first rising edge after the address and enable are applied. The bench drives the address on a falling edge and samples the outputs on the next falling edge. It only does so after the preceding write task has completed, so every expected value comes from the bench's own model as it stands after the writes.

// File: rtl/sw_tlb_pkg.sv
package sw_tlb_pkg;

  localparam int VA_W   = 32;
  localparam int PN_LSB = 10;
  localparam int PN_W   = VA_W - PN_LSB;
  localparam int ASID_W = 4;
  localparam int GRP_W  = 4;
  localparam int SIZE_W = 3;
  localparam int AP_W   = 2 * (1 << GRP_W);

  typedef enum logic [2:0] {
    SEL_CTRL  = 3'd0,
    SEL_EPN   = 3'd1,
    SEL_TWC   = 3'd2,
    SEL_RPN   = 3'd3,
    SEL_CASID = 3'd4,
    SEL_AP    = 3'd5
  } cfgSel_e;

  typedef struct packed {
    logic              valid;
    logic [PN_W-1:0]   epn;
    logic [ASID_W-1:0] asid;
    logic [SIZE_W-1:0] size;
    logic [GRP_W-1:0]  group;
    logic [PN_W-1:0]   rpn;
    logic              ci;
    logic [1:0]        pp;
  } tlbEntry_t;

  // strobes from control to datapath
  typedef struct packed {
    logic commit;
    logic invAll;
    logic keepTop;
  } tlbStrobe_t;

  // mask of page-number bits compared/substituted for a size code
  function automatic logic [PN_W-1:0] pageMask(input logic [SIZE_W-1:0] size);
    logic [PN_W-1:0] one;
    int extra;
    one = PN_W'(1);
    case (size)
      3'd1:    extra = 2;
      3'd2:    extra = 4;
      3'd3:    extra = 9;
      3'd4:    extra = 13;
      default: extra = 0;
    endcase
    return ~((one << extra) - one);
  endfunction

endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import sw_tlb_pkg::*;
#(
  parameter int ENTRIES   = 32,
  parameter int RSV_COUNT = 4,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [2:0]        cfgSel,
  input  logic [VA_W-1:0]   cfgWrData,
  input  logic              invAll,
  output tlbStrobe_t        stb,
  output logic [IDX_W-1:0]  wrIdx,
  output tlbEntry_t         newEntry,
  output logic [ASID_W-1:0] casid,
  output logic [AP_W-1:0]   apReg,
  output logic              defCi
);

  localparam int LAST_FREE = ENTRIES - RSV_COUNT - 1;
  localparam int IDX_LSB   = 8;
  localparam int RSV_BIT   = 27;
  localparam int CI_BIT    = 29;

  logic selCtrl, selEpn, selTwc, selRpn, selCasid, selAp;
  logic keepTop;
  logic [PN_W-1:0]   epnPn;
  logic              epnValid;
  logic [ASID_W-1:0] epnAsid;
  logic [SIZE_W-1:0] twcSize;
  logic [GRP_W-1:0]  twcGroup;
  logic [IDX_W-1:0]  idxNext;

  always_comb begin
    selCtrl  = cfgWrEn && (cfgSel == SEL_CTRL);
    selEpn   = cfgWrEn && (cfgSel == SEL_EPN);
    selTwc   = cfgWrEn && (cfgSel == SEL_TWC);
    selRpn   = cfgWrEn && (cfgSel == SEL_RPN);
    selCasid = cfgWrEn && (cfgSel == SEL_CASID);
    selAp    = cfgWrEn && (cfgSel == SEL_AP);
  end

  // replacement index advance with optional reserved-region skip
  always_comb begin
    if (keepTop && (wrIdx == IDX_W'(LAST_FREE)))
      idxNext = '0;
    else if (wrIdx == IDX_W'(ENTRIES - 1))
      idxNext = '0;
    else
      idxNext = wrIdx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrIdx   <= '0;
      keepTop <= 1'b0;
      defCi   <= 1'b0;
    end else if (selCtrl) begin
      wrIdx   <= cfgWrData[IDX_LSB +: IDX_W];
      keepTop <= cfgWrData[RSV_BIT];
      defCi   <= cfgWrData[CI_BIT];
    end else if (selRpn) begin
      wrIdx   <= idxNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      epnPn    <= '0;
      epnValid <= 1'b0;
      epnAsid  <= '0;
    end else if (selEpn) begin
      epnPn    <= cfgWrData[VA_W-1:PN_LSB];
      epnValid <= cfgWrData[9];
      epnAsid  <= cfgWrData[ASID_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      twcSize  <= '0;
      twcGroup <= '0;
    end else if (selTwc) begin
      twcSize  <= cfgWrData[SIZE_W-1:0];
      twcGroup <= cfgWrData[4 +: GRP_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      casid <= '0;
      apReg <= '0;
    end else begin
      if (selCasid) casid <= cfgWrData[ASID_W-1:0];
      if (selAp)    apReg <= cfgWrData[AP_W-1:0];
    end
  end

  always_comb begin
    newEntry.valid = epnValid;
    newEntry.epn   = epnPn;
    newEntry.asid  = epnAsid;
    newEntry.size  = twcSize;
    newEntry.group = twcGroup;
    newEntry.rpn   = cfgWrData[VA_W-1:PN_LSB];
    newEntry.ci    = cfgWrData[1];
    newEntry.pp    = cfgWrData[5:4];
    stb.commit     = selRpn;
    stb.invAll     = invAll;
    stb.keepTop    = keepTop;
  end

endmodule

// File: rtl/tlb_array.sv
module tlb_array
  import sw_tlb_pkg::*;
#(
  parameter int ENTRIES   = 32,
  parameter int RSV_COUNT = 4,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  tlbStrobe_t        stb,
  input  logic [IDX_W-1:0]  wrIdx,
  input  tlbEntry_t         newEntry,
  input  logic [ASID_W-1:0] casid,
  input  logic [AP_W-1:0]   apReg,
  input  logic              defCi,
  input  logic              xlateEn,
  input  logic [VA_W-1:0]   lkVa,
  output logic              lkHit,
  output logic [VA_W-1:0]   lkPa,
  output logic              lkCi,
  output logic [1:0]        lkAp,
  output logic [1:0]        lkPp,
  output logic [ENTRIES-1:0] validVec
);

  tlbEntry_t        ent [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic [IDX_W-1:0] selIdx;
  logic             anyHit;
  tlbEntry_t        selEnt;
  logic [PN_W-1:0]  selMask;
  logic [VA_W-1:0]  hitPa;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    localparam bit IS_TOP = (g >= ENTRIES - RSV_COUNT);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ent[g].valid <= 1'b0;
      end else if (stb.commit && (wrIdx == IDX_W'(g))) begin
        ent[g] <= newEntry;
      end else if (stb.invAll && !(IS_TOP && stb.keepTop)) begin
        ent[g].valid <= 1'b0;
      end
    end

    always_comb begin
      match[g] = ent[g].valid && (ent[g].asid == casid) &&
                 (((ent[g].epn ^ lkVa[VA_W-1:PN_LSB]) & pageMask(ent[g].size)) == '0);
    end

    assign validVec[g] = ent[g].valid;
  end

  // lowest slot wins
  always_comb begin
    selIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) selIdx = IDX_W'(i);
    end
    anyHit = |match;
  end

  always_comb begin
    selEnt  = ent[selIdx];
    selMask = pageMask(selEnt.size);
    hitPa   = {(selEnt.rpn & selMask) | (lkVa[VA_W-1:PN_LSB] & ~selMask),
               lkVa[PN_LSB-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lkHit <= 1'b0;
      lkPa  <= '0;
      lkCi  <= 1'b0;
      lkAp  <= '0;
      lkPp  <= '0;
    end else if (!xlateEn) begin
      lkHit <= 1'b1;
      lkPa  <= lkVa;
      lkCi  <= defCi;
      lkAp  <= 2'b01;
      lkPp  <= '0;
    end else if (anyHit) begin
      lkHit <= 1'b1;
      lkPa  <= hitPa;
      lkCi  <= selEnt.ci;
      lkAp  <= apReg[{selEnt.group, 1'b0} +: 2];
      lkPp  <= selEnt.pp;
    end else begin
      lkHit <= 1'b0;
      lkPa  <= '0;
      lkCi  <= 1'b0;
      lkAp  <= '0;
      lkPp  <= '0;
    end
  end

endmodule

// File: rtl/sw_tlb.sv
module sw_tlb
  import sw_tlb_pkg::*;
#(
  parameter int ENTRIES   = 32,
  parameter int RSV_COUNT = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic [2:0]  cfgSel,
  input  logic [31:0] cfgWrData,
  input  logic        invAll,
  input  logic        xlateEn,
  input  logic [31:0] lkVa,
  output logic        lkHit,
  output logic [31:0] lkPa,
  output logic        lkCi,
  output logic [1:0]  lkAp,
  output logic [1:0]  lkPp
);

  localparam int IDX_W = $clog2(ENTRIES);

  tlbStrobe_t        ctlStb;
  logic [IDX_W-1:0]  wrIdx;
  tlbEntry_t         newEntry;
  logic [ASID_W-1:0] casid;
  logic [AP_W-1:0]   apReg;
  logic              defCi;
  logic [ENTRIES-1:0] validVec;

  tlb_ctrl #(.ENTRIES(ENTRIES), .RSV_COUNT(RSV_COUNT)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgSel    (cfgSel),
    .cfgWrData (cfgWrData),
    .invAll    (invAll),
    .stb       (ctlStb),
    .wrIdx     (wrIdx),
    .newEntry  (newEntry),
    .casid     (casid),
    .apReg     (apReg),
    .defCi     (defCi)
  );

  tlb_array #(.ENTRIES(ENTRIES), .RSV_COUNT(RSV_COUNT)) u_array (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (ctlStb),
    .wrIdx    (wrIdx),
    .newEntry (newEntry),
    .casid    (casid),
    .apReg    (apReg),
    .defCi    (defCi),
    .xlateEn  (xlateEn),
    .lkVa     (lkVa),
    .lkHit    (lkHit),
    .lkPa     (lkPa),
    .lkCi     (lkCi),
    .lkAp     (lkAp),
    .lkPp     (lkPp),
    .validVec (validVec)
  );

endmodule

// File: rtl/sw_tlb_chk.sv
module sw_tlb_chk #(
  parameter int ENTRIES   = 32,
  parameter int RSV_COUNT = 4,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rstN,
  input logic               xlateEn,
  input logic [31:0]        lkVa,
  input logic               lkHit,
  input logic [31:0]        lkPa,
  input logic               lkCi,
  input logic [1:0]         lkAp,
  input logic [1:0]         lkPp,
  input logic               defCi,
  input logic               commit,
  input logic               invAll,
  input logic               keepTop,
  input logic [IDX_W-1:0]   wrIdx,
  input logic [ENTRIES-1:0] validVec
);

  localparam int LAST_FREE = ENTRIES - RSV_COUNT - 1;

  logic armed;
  always_ff @(posedge clk) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  function automatic logic [IDX_W-1:0] stepIdx(input logic [IDX_W-1:0] cur, input logic rsv);
    if (rsv && cur == IDX_W'(LAST_FREE)) return '0;
    if (cur == IDX_W'(ENTRIES - 1)) return '0;
    return cur + 1'b1;
  endfunction

  p_xoff_pass_r8: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(!xlateEn) |->
      lkHit && (lkPa == $past(lkVa)) && (lkCi == $past(defCi)) && (lkAp == 2'b01))
    else $error("translation-off passthrough broken");

  p_miss_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    !lkHit |-> (lkPa == '0) && !lkCi && (lkAp == '0) && (lkPp == '0))
    else $error("miss result not cleared");

  p_index_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(commit) |-> wrIdx == stepIdx($past(wrIdx), $past(keepTop)))
    else $error("replacement index did not advance");

  p_inv_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(invAll && !keepTop && !commit) |-> validVec == '0)
    else $error("invalidate left valid entries");

  p_keep_top_r7: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(invAll && keepTop && !commit) |->
      (validVec[ENTRIES-1 -: RSV_COUNT] == $past(validVec[ENTRIES-1 -: RSV_COUNT])) &&
      (validVec[ENTRIES-RSV_COUNT-1:0] == '0))
    else $error("reserved entries not preserved");

endmodule

bind sw_tlb sw_tlb_chk #(.ENTRIES(ENTRIES), .RSV_COUNT(RSV_COUNT)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .xlateEn  (xlateEn),
  .lkVa     (lkVa),
  .lkHit    (lkHit),
  .lkPa     (lkPa),
  .lkCi     (lkCi),
  .lkAp     (lkAp),
  .lkPp     (lkPp),
  .defCi    (defCi),
  .commit   (ctlStb.commit),
  .invAll   (ctlStb.invAll),
  .keepTop  (ctlStb.keepTop),
  .wrIdx    (wrIdx),
  .validVec (validVec)
);

// File: tb/test_sw_tlb.sv
module test_sw_tlb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [2:0]  cfgSel = '0;
  logic [31:0] cfgWrData = '0;
  logic        invAll = 1'b0;
  logic        xlateEn = 1'b1;
  logic [31:0] lkVa = '0;
  logic        lkHit;
  logic [31:0] lkPa;
  logic        lkCi;
  logic [1:0]  lkAp;
  logic [1:0]  lkPp;

  int vectors = 0;
  int miscomp = 0;
  bit done = 1'b0;

  // bench model
  bit          mValid [32];
  logic [31:0] mEpnR  [32];
  logic [31:0] mTwcR  [32];
  logic [31:0] mRpnR  [32];
  logic [31:0] mCtrl = '0, mEpn = '0, mTwc = '0, mAp = '0;
  logic [3:0]  mCasid = '0;
  int          mIdx = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sw_tlb i_sw_tlb (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgWrData(cfgWrData), .invAll(invAll), .xlateEn(xlateEn),
    .lkVa(lkVa), .lkHit(lkHit), .lkPa(lkPa), .lkCi(lkCi),
    .lkAp(lkAp), .lkPp(lkPp)
  );

  function automatic int offBits(input logic [2:0] sz);
    case (sz)
      3'd1: return 12;
      3'd2: return 14;
      3'd3: return 19;
      3'd4: return 23;
      default: return 10;
    endcase
  endfunction

  function automatic logic [37:0] expLk(input logic [31:0] va, input logic xon);
    if (!xon) return {1'b1, va, mCtrl[29], 2'b01, 2'b00};
    for (int i = 0; i < 32; i++) begin
      int off;
      off = offBits(mTwcR[i][2:0]);
      if (mValid[i] && (mEpnR[i][3:0] == mCasid) && ((va >> off) == (mEpnR[i] >> off))) begin
        logic [31:0] pa;
        logic [3:0]  grp;
        pa  = ((mRpnR[i] >> off) << off) | (va & ((32'd1 << off) - 32'd1));
        grp = mTwcR[i][7:4];
        return {1'b1, pa, mRpnR[i][1], mAp[2*grp +: 2], mRpnR[i][5:4]};
      end
    end
    return '0;
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
    case (sel)
      3'd0: begin mCtrl = d; mIdx = int'(d[12:8]); end
      3'd1: mEpn = d;
      3'd2: mTwc = d;
      3'd3: begin
        mValid[mIdx] = mEpn[9];
        mEpnR[mIdx] = mEpn; mTwcR[mIdx] = mTwc; mRpnR[mIdx] = d;
        if (mCtrl[27] && mIdx == 27) mIdx = 0;
        else mIdx = (mIdx + 1) % 32;
      end
      3'd4: mCasid = d[3:0];
      3'd5: mAp = d;
      default: ;
    endcase
  endtask

  task automatic setCtrl(input int idx, input bit rsv, input bit ci);
    wr(3'd0, (32'(ci) << 29) | (32'(rsv) << 27) | (32'(idx) << 8));
  endtask

  // asid / group / size fields, valid set
  task automatic load(input logic [31:0] va, input logic [3:0] asid, input logic [2:0] sz,
                      input logic [3:0] grp, input logic [31:0] rpn);
    wr(3'd1, (va & 32'hFFFF_FC00) | 32'h200 | 32'(asid));
    wr(3'd2, (32'(grp) << 4) | 32'(sz));
    wr(3'd3, rpn);
  endtask

  task automatic pulseInv();
    @(negedge clk); invAll = 1'b1;
    @(negedge clk); invAll = 1'b0;
    for (int i = 0; i < 32; i++)
      if (!(mCtrl[27] && i >= 28)) mValid[i] = 1'b0;
  endtask

  task automatic chk(input logic [31:0] va, input logic xon, input string req);
    logic [37:0] got, exp;
    @(negedge clk);
    lkVa = va; xlateEn = xon;
    @(negedge clk);
    got = {lkHit, lkPa, lkCi, lkAp, lkPp};
    exp = expLk(va, xon);
    vectors++;
    if (got !== exp) begin
      miscomp++;
      $display("FAIL %s va=%h: got %h expected %h", req, va, got, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      vectors++; miscomp++;
      $display("FAIL watchdog: got hung run expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      mValid[i] = 0; mEpnR[i] = '0; mTwcR[i] = '0; mRpnR[i] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R12 reset state, R8 default attribute
    chk(32'h1234_5678, 1'b1, "R12");
    chk(32'h1234_5678, 1'b0, "R8");

    wr(3'd5, 32'h5555_5555);

    // R2 each page size, committed at slots 0..4 (R5)
    setCtrl(0, 0, 0);
    for (int k = 0; k < 5; k++)
      load(32'h0100_0000 * (k + 1), 4'd0, 3'(k), 4'd0, 32'h8000_0000 + 32'h0100_0000 * k + 32'h12);
    for (int k = 0; k < 5; k++) begin
      int off;
      off = offBits(3'(k));
      chk(32'h0100_0000 * (k + 1) + (32'd1 << off) - 32'd4, 1'b1, "R2");
      chk(32'h0100_0000 * (k + 1) + (32'd1 << off), 1'b1, "R2");
    end

    // R3 staging only
    wr(3'd1, 32'h0A00_0200);
    wr(3'd2, 32'h0000_0001);
    chk(32'h0A00_0000, 1'b1, "R3");
    chk(32'h0100_0004, 1'b1, "R3");

    // R4 explicit slot overwrite
    setCtrl(1, 0, 0);
    load(32'h0B00_0000, 4'd0, 3'd1, 4'd0, 32'h9000_0000);
    chk(32'h0200_0100, 1'b1, "R4");
    chk(32'h0B00_0123, 1'b1, "R4");

    // R11 lowest slot wins, R1 any slot
    setCtrl(20, 0, 0);
    load(32'h0C00_0000, 4'd0, 3'd0, 4'd0, 32'hA000_0000);
    chk(32'h0C00_0010, 1'b1, "R1");
    setCtrl(5, 0, 0);
    load(32'h0C00_0000, 4'd0, 3'd0, 4'd0, 32'hB000_0000);
    chk(32'h0C00_0010, 1'b1, "R11");
    setCtrl(3, 0, 0);
    load(32'h0C00_0000, 4'd0, 3'd0, 4'd0, 32'hC000_0000);
    chk(32'h0C00_0010, 1'b1, "R11");

    // R9 address-space ID
    load(32'h0D00_0000, 4'd3, 3'd1, 4'd0, 32'hD000_0000);
    chk(32'h0D00_0044, 1'b1, "R9");
    wr(3'd4, 32'd3);
    chk(32'h0D00_0044, 1'b1, "R9");
    chk(32'h0100_0004, 1'b1, "R9");
    wr(3'd4, 32'd0);

    // R10 access groups read at lookup time
    wr(3'd5, 32'hE4E4_E4E4);
    load(32'h0E00_0000, 4'd0, 3'd0, 4'd7, 32'hE000_0032);
    chk(32'h0E00_0008, 1'b1, "R10");
    wr(3'd5, 32'h0000_8000);
    chk(32'h0E00_0008, 1'b1, "R10");

    // R5 wrap 31->0 and 27->0 with reserve
    setCtrl(31, 0, 0);
    load(32'h0F00_0000, 4'd0, 3'd0, 4'd0, 32'hF000_0000);
    load(32'h1000_0000, 4'd0, 3'd0, 4'd0, 32'hF100_0000);
    chk(32'h0100_0004, 1'b1, "R5");
    chk(32'h1000_0004, 1'b1, "R5");
    setCtrl(27, 1, 0);
    load(32'h1100_0000, 4'd0, 3'd0, 4'd0, 32'hF200_0000);
    load(32'h1200_0000, 4'd0, 3'd0, 4'd0, 32'hF300_0000);
    chk(32'h1000_0004, 1'b1, "R5");
    chk(32'h1200_0004, 1'b1, "R5");

    // R7 reserved entries survive invalidate
    setCtrl(28, 1, 0);
    for (int k = 0; k < 4; k++)
      load(32'h2000_0000 + 32'h0100_0000 * k, 4'd0, 3'd4, 4'd1, 32'h4000_0000 + 32'h0100_0000 * k);
    pulseInv();
    chk(32'h2000_0100, 1'b1, "R7");
    chk(32'h2300_0100, 1'b1, "R7");
    chk(32'h1200_0004, 1'b1, "R7");

    // R6 full invalidate
    setCtrl(0, 0, 0);
    pulseInv();
    chk(32'h2000_0100, 1'b1, "R6");

    // R8 default cache-inhibit when off, R13 back-to-back
    setCtrl(0, 0, 1);
    chk(32'hDEAD_BEEF, 1'b0, "R8");
    chk(32'hDEAD_BEEF, 1'b1, "R13");
    load(32'h0300_0000, 4'd0, 3'd2, 4'd2, 32'h7700_0000);
    chk(32'h0300_2000, 1'b1, "R13");
    chk(32'h0300_4000, 1'b1, "R13");

    // constrained random
    void'($urandom(32'd2024));
    for (int n = 0; n < 400; n++) begin
      int r;
      r = int'($urandom % 10);
      if (r < 3)
        load((($urandom % 8) << 23) | ($urandom % (1 << 23)), 4'($urandom % 2),
             3'($urandom % 8), 4'($urandom % 16), $urandom);
      else if (r == 3)
        setCtrl(int'($urandom % 32), bit'($urandom % 2), bit'($urandom % 2));
      else if (r == 4 && ($urandom % 4) == 0)
        pulseInv();
      else if (r == 5)
        wr(3'd4, $urandom % 2);
      else if (r == 6)
        wr(3'd5, $urandom);
      chk((($urandom % 8) << 23) | ($urandom % (1 << 23)), ($urandom % 10) != 0, "R1");
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule